// File: doc/BRIEF.md
# Ping-Pong Frame Buffer with Two-Lane Serial Readout

This block buffers a frame of 16-bit words while the frame before it is shifted out serially. Four single-port word arrays form two banks. One bank takes the incoming words of the current frame, and the other bank is drained onto two serial lines. A single frame-start pulse closes the frame being written and swaps the roles of the two banks. The same pulse starts the readout of the frame that has just closed.

Words alternate between the two lanes. Even-numbered words of a frame go to lane 0 and odd-numbered words go to lane 1. Each lane first sends its own word count as a header word, then its data words, least significant bit first. Lane 1 pads with zero words so that both lanes finish together. A bit-enable strobe marks each cycle that carries a new bit, and a frame marker flags the very first bit. A rate select runs the lanes either at the core clock or at half of it. The total word count and an overflow flag for the frame being read are presented as parallel outputs.

Top module: `pingpong_serial_buf`

## Requirements
- R1: Words written between two frame-start pulses come out intact in the readout that the second pulse starts, while the next frame is being written into the other bank at the same time.
- R2: Word k of a frame (counting from 0) is stored on lane k mod 2 at lane position k/2. Each lane sends its stored words in increasing position order.
- R3: Every serial word is sent least significant bit first, 16 bits per word, with no gap between words.
- R4: Each lane's first word is a header holding that lane's word count. For a frame of n accepted words, lane 0's count is ceil(n/2) and lane 1's count is floor(n/2).
- R5: After its header, each lane sends exactly ceil(n/2) data words. Lane 1 sends a zero word in the last slot when n is odd.
- R6: At most 2*LANE_DEPTH words are accepted per frame, and later writes in that frame are dropped. On the frame-start pulse, `hdr_total` takes the accepted count and `hdr_ovf` takes 1 if any write was dropped. Both hold their value until the next pulse.
- R7: `frame_mark` is high exactly once per readout. It rises together with `bit_en` on the first bit of the lane headers and is never high without `bit_en`.
- R8: With `slow_rate`=0, `bit_en` is high on every cycle of a readout. With `slow_rate`=1, `bit_en` is high on every second cycle. Serial data is valid on cycles where `bit_en` is high.
- R9: A frame-start pulse aborts any readout that is still running and starts the new one. `bit_en` stays low in the cycle after the pulse. A word written in the same cycle as the pulse is word 0 of the new frame.
- R10: After reset, and after the last bit of a readout, `bit_en`, `frame_mark`, `ser_d0` and `ser_d1` stay 0 until the next frame-start pulse has taken effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse that closes the frame, swaps the banks and starts the readout |
| wr_valid | input | 1 | Write strobe for wr_data |
| wr_data | input | WORD_W | Next word of the current frame |
| slow_rate | input | 1 | 1 selects half-rate serial output |
| ser_d0 | output | 1 | Serial data of lane 0 (even words) |
| ser_d1 | output | 1 | Serial data of lane 1 (odd words) |
| bit_en | output | 1 | High on cycles that carry a new serial bit |
| frame_mark | output | 1 | High on the first bit of each readout |
| hdr_total | output | TW | Accepted word count of the frame being read |
| hdr_ovf | output | 1 | Writes were dropped in the frame being read |

## Verification
Frame lengths are swept from empty up to two words past capacity, at both rates. Each length is written while the previous frame drains, so the sweep separates correct bank swapping from stale bank contents. Odd and even lengths show whether the ceil/floor split and the lane-1 padding are right. Lengths just past capacity show the drop-and-flag behaviour against a saturated count. A readout cut short by an early pulse, followed by full readouts, shows whether the restart discards the old shift state and puts the marker on the new header. The spacing of `bit_en` in each mode distinguishes the two rates.

// File: rtl/pingpong_serial_buf.sv
module pingpong_serial_buf #(
  parameter int WORD_W     = 16,
  parameter int LANE_DEPTH = 2048
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   frame_start,
  input  logic                                   wr_valid,
  input  logic [WORD_W-1:0]                      wr_data,
  input  logic                                   slow_rate,
  output logic                                   ser_d0,
  output logic                                   ser_d1,
  output logic                                   bit_en,
  output logic                                   frame_mark,
  output logic [$clog2(2*LANE_DEPTH+1)-1:0]      hdr_total,
  output logic                                   hdr_ovf
);
  localparam int AW = $clog2(LANE_DEPTH);
  localparam int CW = $clog2(LANE_DEPTH + 1);
  localparam int TW = $clog2(2*LANE_DEPTH + 1);
  localparam int BW = $clog2(WORD_W);

  logic [WORD_W-1:0] mem [4][LANE_DEPTH];

  logic          wbank;
  logic [TW-1:0] wcnt;
  logic          wovf;

  wire          wbank_eff = frame_start ? ~wbank : wbank;
  wire [TW-1:0] widx      = frame_start ? '0 : wcnt;
  wire          wfit      = widx < TW'(2*LANE_DEPTH);
  wire          wr_go     = wr_valid && wfit;
  wire [AW-1:0] waddr     = AW'(widx >> 1);
  wire          wlane     = widx[0];

  wire [CW-1:0] n0 = CW'((wcnt + TW'(1)) >> 1);
  wire [CW-1:0] n1 = CW'(wcnt >> 1);

  always_ff @(posedge clk)
    if (wr_go) mem[{wbank_eff, wlane}][waddr] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbank     <= 1'b0;
      wcnt      <= '0;
      wovf      <= 1'b0;
      hdr_total <= '0;
      hdr_ovf   <= 1'b0;
    end else if (frame_start) begin
      wbank     <= ~wbank;
      wcnt      <= wr_go ? TW'(1) : '0;
      wovf      <= 1'b0;
      hdr_total <= wcnt;
      hdr_ovf   <= wovf;
    end else if (wr_valid) begin
      if (wfit) wcnt <= wcnt + TW'(1);
      else      wovf <= 1'b1;
    end
  end

  logic [CW-1:0]     c0, c1, raddr, wordn;
  logic [BW-1:0]     bitn;
  logic              active, phase;
  logic [WORD_W-1:0] sh0, sh1, rdq0, rdq1;

  wire tick = active && (!slow_rate || phase);

  always_ff @(posedge clk) begin
    rdq0 <= mem[{~wbank, 1'b0}][AW'(raddr)];
    rdq1 <= mem[{~wbank, 1'b1}][AW'(raddr)];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; phase <= 1'b0;
      c0 <= '0; c1 <= '0; raddr <= '0; wordn <= '0; bitn <= '0;
      sh0 <= '0; sh1 <= '0;
      ser_d0 <= 1'b0; ser_d1 <= 1'b0; bit_en <= 1'b0; frame_mark <= 1'b0;
    end else if (frame_start) begin
      active <= 1'b1; phase <= 1'b0;
      c0 <= n0; c1 <= n1; raddr <= '0; wordn <= '0; bitn <= '0;
      sh0 <= WORD_W'(n0);
      sh1 <= WORD_W'(n1);
      ser_d0 <= 1'b0; ser_d1 <= 1'b0; bit_en <= 1'b0; frame_mark <= 1'b0;
    end else if (!active) begin
      ser_d0 <= 1'b0; ser_d1 <= 1'b0; bit_en <= 1'b0; frame_mark <= 1'b0;
    end else begin
      phase <= ~phase;
      if (tick) begin
        ser_d0     <= sh0[0];
        ser_d1     <= sh1[0];
        bit_en     <= 1'b1;
        frame_mark <= (wordn == '0) && (bitn == '0);
        if (bitn == BW'(WORD_W-1)) begin
          bitn <= '0;
          if (wordn == c0) begin
            active <= 1'b0;
          end else begin
            sh0   <= (raddr < c0) ? rdq0 : '0;
            sh1   <= (raddr < c1) ? rdq1 : '0;
            raddr <= raddr + CW'(1);
            wordn <= wordn + CW'(1);
          end
        end else begin
          bitn <= bitn + BW'(1);
          sh0  <= sh0 >> 1;
          sh1  <= sh1 >> 1;
        end
      end else begin
        bit_en     <= 1'b0;
        frame_mark <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pingpong_serial_buf_chk.sv
module pingpong_serial_buf_chk #(
  parameter int TW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_start,
  input logic          slow_rate,
  input logic          bit_en,
  input logic          frame_mark,
  input logic [TW-1:0] hdr_total,
  input logic          hdr_ovf
);
  AST_MARK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_mark |-> bit_en); // R7

  AST_SLOW_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && slow_rate) |=> !bit_en); // R8

  AST_RESTART_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !bit_en); // R9

  AST_HDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(hdr_total) && $stable(hdr_ovf))); // R6
endmodule

bind pingpong_serial_buf pingpong_serial_buf_chk #(.TW($clog2(2*LANE_DEPTH+1))) i_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .slow_rate(slow_rate),
  .bit_en(bit_en), .frame_mark(frame_mark), .hdr_total(hdr_total), .hdr_ovf(hdr_ovf)
);

// File: tb/test_pingpong_serial_buf.sv
`timescale 1ns/1ps
module test_pingpong_serial_buf;
  localparam int D  = 4;
  localparam int TW = $clog2(2*D+1);

  logic clk = 1'b0, rst_n = 1'b0, frame_start = 1'b0, wr_valid = 1'b0, slow_rate = 1'b0;
  logic [15:0] wr_data = '0;
  logic ser_d0, ser_d1, bit_en, frame_mark, hdr_ovf;
  logic [TW-1:0] hdr_total;

  pingpong_serial_buf #(.WORD_W(16), .LANE_DEPTH(D)) i_pingpong_serial_buf (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .wr_valid(wr_valid),
    .wr_data(wr_data), .slow_rate(slow_rate), .ser_d0(ser_d0), .ser_d1(ser_d1),
    .bit_en(bit_en), .frame_mark(frame_mark), .hdr_total(hdr_total), .hdr_ovf(hdr_ovf)
  );

  always #5 clk = ~clk;

  int nv = 0, nf = 0, cyc = 0, nb = 0, marks = 0, markpos = 0, first_c = 0, last_c = 0;
  bit done = 0;
  logic cap0 [256];
  logic cap1 [256];
  int pend [16];
  int nxt [16];
  int pend_n = 0, fid = 0;

  always @(negedge clk) begin
    cyc++;
    if (bit_en && nb < 256) begin
      cap0[nb] = ser_d0;
      cap1[nb] = ser_d1;
      if (frame_mark) begin marks++; markpos = nb; end
      if (nb == 0) first_c = cyc;
      last_c = cyc;
      nb++;
    end
  end

  task automatic chk(string req, int act, int exp);
    nv++;
    if (act != exp) begin
      nf++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int val(int f, int j);
    return (f * 7919 + j * 1237 + 16'h0101) & 16'hFFFF;
  endfunction

  function automatic int lane_word(bit lane, int w);
    int v = 0;
    for (int b = 0; b < 16; b++)
      if (lane ? cap1[16*w+b] : cap0[16*w+b]) v |= (1 << b);
    return v;
  endfunction

  task automatic step(int nnext, bit slow, bit trunc);
    int acc, c0, c1, waitc;
    slow_rate = slow;
    fid++;
    for (int j = 0; j < nnext; j++) nxt[j] = val(fid, j);
    @(negedge clk);
    frame_start = 1'b1;
    wr_valid = (nnext > 0);
    wr_data = 16'(nxt[0]);
    @(negedge clk);
    frame_start = 1'b0;
    nb = 0; marks = 0; markpos = -1;
    for (int j = 1; j < nnext; j++) begin
      wr_valid = 1'b1;
      wr_data = 16'(nxt[j]);
      @(negedge clk);
    end
    wr_valid = 1'b0;
    waitc = trunc ? 30 : 190;
    repeat (waitc) @(negedge clk);
    if (!trunc) begin
      acc = (pend_n > 2*D) ? 2*D : pend_n;
      c0 = (acc + 1) / 2;
      c1 = acc / 2;
      chk("R6 hdr_total", int'(hdr_total), acc);
      chk("R6 hdr_ovf", int'(hdr_ovf), (pend_n > 2*D) ? 1 : 0);
      chk("R5 bit count", nb, 16*(1+c0));
      chk("R7 marker count", marks, 1);
      chk("R7 marker position", markpos, 0);
      chk("R8 bit spacing", last_c - first_c, (nb - 1) * (slow ? 2 : 1));
      chk("R4 lane0 header", lane_word(0, 0), c0);
      chk("R4 lane1 header", lane_word(1, 0), c1);
      for (int i = 0; i < c0; i++) begin
        chk("R2 R3 lane0 data", lane_word(0, i+1), pend[2*i]);
        chk("R1 R5 lane1 data", lane_word(1, i+1), (i < c1) ? pend[2*i+1] : 0);
      end
      chk("R10 idle bit_en", int'(bit_en), 0);
      chk("R10 idle data", int'(ser_d0) + int'(ser_d1) + int'(frame_mark), 0);
    end
    for (int j = 0; j < nnext; j++) pend[j] = nxt[j];
    pend_n = nnext;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset bit_en", int'(bit_en), 0);
    chk("R10 reset marker", int'(frame_mark), 0);
    chk("R10 reset data", int'(ser_d0) + int'(ser_d1), 0);
    chk("R6 reset hdr_total", int'(hdr_total), 0);
    for (int r = 0; r < 2; r++)
      for (int n = 0; n <= 2*D + 2; n++)
        step(n, r[0], 1'b0);
    step(8, 1'b0, 1'b1);
    step(3, 1'b0, 1'b0);
    step(0, 1'b1, 1'b0);
    step(5, 1'b0, 1'b0);
    step(0, 1'b0, 1'b0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nv, nf);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      nv++; nf++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nv, nf);
      $finish;
    end
  end
endmodule